// File: doc/BRIEF.md
# Dual-Width Instruction Fetch Pipeline

This block is the front end of a small processor core. It keeps three in-order pipeline slots: fetch, decode and execute. Each slot holds a valid flag, the instruction's address and a 32-bit instruction word. A step strobe advances the pipeline. On a step, every slot's contents move one position toward execute, and a new instruction is requested from a synchronous instruction memory. The decode and execute logic that consume the slots are outside this block.

A mode input selects one of two instruction encodings: a full 32-bit encoding or a compact 16-bit encoding. The mode sets the program counter stride, the alignment applied to the fetch address and the size of the memory read. The program counter is advanced first, and the fetch address is taken from the advanced value. The memory answers one clock after a request. The returned word is written into the fetch slot, or straight into decode if the pipeline steps again in that same cycle. A redirect input loads a new program counter and empties all three slots. The pipeline then refills over the following steps.

Top module: `fetch_pipe`

## Requirements
- R1: While reset is asserted and right after it is released, the program counter reads 0, all three slots are invalid and no memory request is issued.
- R2: On a step without redirect, execute takes decode's valid flag, address and instruction, and decode takes fetch's, all in the same clock edge.
- R3: With the mode input at 0 (32-bit encoding), a step adds 4 to the program counter, the request address is the advanced value with bits [1:0] cleared, and the size output is 0 (word).
- R4: With the mode input at 1 (16-bit encoding), a step adds 2 to the program counter, the request address is the advanced value with bit 0 cleared, and the size output is 1 (halfword).
- R5: After a step, the fetch slot is valid, its address equals the request address formed from the advanced program counter, and the program counter output shows the advanced value.
- R6: Read data on the memory data input one cycle after a request is stored as that request's instruction: in the fetch slot if no step occurs in that cycle, otherwise directly in the decode slot.
- R7: For a halfword request, the stored instruction is bits [15:0] of the read data with bits [31:16] set to zero.
- R8: A redirect loads the given program counter, clears all three valid flags, issues no request and discards any outstanding read data. It takes priority over a step in the same cycle.
- R9: In a cycle with neither step nor redirect, the program counter and the valid flags, addresses and instructions of the decode and execute slots stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance the pipeline by one slot |
| narrow_i | input | 1 | Encoding select: 0 = 32-bit, 1 = 16-bit |
| redir_i | input | 1 | Load a new program counter and empty the pipeline |
| redir_pc_i | input | 32 | Program counter value loaded on redirect |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Aligned read address |
| mem_half_o | output | 1 | Read size: 0 = word, 1 = halfword |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| pc_o | output | 32 | Current program counter |
| fet_vld_o | output | 1 | Fetch slot valid |
| fet_addr_o | output | 32 | Fetch slot address |
| fet_insn_o | output | 32 | Fetch slot instruction |
| dec_vld_o | output | 1 | Decode slot valid |
| dec_addr_o | output | 32 | Decode slot address |
| dec_insn_o | output | 32 | Decode slot instruction |
| exe_vld_o | output | 1 | Execute slot valid |
| exe_addr_o | output | 32 | Execute slot address |
| exe_insn_o | output | 32 | Execute slot instruction |

## Verification
A wrong program counter appears on the next request address, in the same cycle it is formed. Because the pipeline shifts, it also reaches the decode and execute addresses one and two steps later. A lost or misrouted read shows as a wrong instruction in the fetch slot one cycle after the request, or in decode when steps are back to back. A stale pending flag after a redirect writes a discarded word into the new fetch slot. A wrong size latch shows as nonzero upper bits on a halfword fetch. The reference model compares every slot, the program counter and the memory request on every clock, so any of these faults is reported within a cycle or two of its cause.

// File: rtl/fetch_pipe_pkg.sv
package fetch_pipe_pkg;
  parameter int unsigned AW   = 32;
  parameter int unsigned IW   = 32;
  parameter int unsigned NSTG = 3;
  localparam int unsigned HW  = IW / 2;

  typedef struct packed {
    logic          vld;
    logic [AW-1:0] addr;
    logic [IW-1:0] insn;
  } slot_t;

  // Program counter stride for the selected encoding.
  function automatic logic [AW-1:0] pc_stride(input logic narrow);
    return narrow ? AW'(2) : AW'(4);
  endfunction

  // Clear the low address bits that the selected encoding never uses.
  function automatic logic [AW-1:0] align_fetch(input logic [AW-1:0] a,
                                                input logic narrow);
    return narrow ? {a[AW-1:1], 1'b0} : {a[AW-1:2], 2'b00};
  endfunction

  // Halfword reads keep only the low half, zero-extended.
  function automatic logic [IW-1:0] shape_insn(input logic [IW-1:0] raw,
                                               input logic half);
    return half ? {{(IW-HW){1'b0}}, raw[HW-1:0]} : raw;
  endfunction
endpackage

// File: rtl/fp_pc_unit.sv
module fp_pc_unit
  import fetch_pipe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [AW-1:0] load_pc,
  input  logic          narrow,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] fetch_addr
);
  logic [AW-1:0] pc_next;

  assign pc_next    = pc_q + pc_stride(narrow);
  assign fetch_addr = align_fetch(pc_next, narrow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (load) pc_q <= load_pc;
    else if (adv)  pc_q <= pc_next;
  end
endmodule

// File: rtl/fp_fill_track.sv
module fp_fill_track
  import fetch_pipe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic          narrow,
  input  logic [IW-1:0] raw,
  output logic          pend,
  output logic [IW-1:0] fill_word
);
  logic half_q;

  assign fill_word = shape_insn(raw, half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      half_q <= 1'b0;
    end else if (load) begin
      pend   <= 1'b0;
    end else if (adv) begin
      pend   <= 1'b1;
      half_q <= narrow;
    end else begin
      pend   <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_slot_chain.sv
module fp_slot_chain
  import fetch_pipe_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  load,
  input  logic                  pend,
  input  logic [IW-1:0]         fill_word,
  input  logic [AW-1:0]         new_addr,
  output slot_t [NSTG-1:0]      slots
);
  for (genvar g = 0; g < NSTG; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slots[g] <= '0;
        end else if (load) begin
          slots[g].vld <= 1'b0;
        end else if (adv) begin
          slots[g].vld  <= 1'b1;
          slots[g].addr <= new_addr;
          slots[g].insn <= '0;
        end else if (pend) begin
          slots[g].insn <= fill_word;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slots[g] <= '0;
        end else if (load) begin
          slots[g].vld <= 1'b0;
        end else if (adv) begin
          slots[g] <= slots[g-1];
          if (g == 1 && pend) slots[g].insn <= fill_word;
        end
      end
    end
  end
endmodule

// File: rtl/fetch_pipe.sv
module fetch_pipe
  import fetch_pipe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          narrow_i,
  input  logic          redir_i,
  input  logic [31:0]   redir_pc_i,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  output logic          mem_half_o,
  input  logic [31:0]   mem_rdata_i,
  output logic [31:0]   pc_o,
  output logic          fet_vld_o,
  output logic [31:0]   fet_addr_o,
  output logic [31:0]   fet_insn_o,
  output logic          dec_vld_o,
  output logic [31:0]   dec_addr_o,
  output logic [31:0]   dec_insn_o,
  output logic          exe_vld_o,
  output logic [31:0]   exe_addr_o,
  output logic [31:0]   exe_insn_o
);
  localparam int unsigned S_FET = 0;
  localparam int unsigned S_DEC = 1;
  localparam int unsigned S_EXE = NSTG - 1;

  // Named internal events used by the checker.
  logic do_flush;
  logic do_step;
  logic fill_pend;

  logic [AW-1:0]      fetch_addr;
  logic [IW-1:0]      fill_word;
  slot_t [NSTG-1:0]   slots;

  assign do_flush = redir_i;
  assign do_step  = step_i & ~redir_i;

  fp_pc_unit u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (do_step),
    .load       (do_flush),
    .load_pc    (redir_pc_i),
    .narrow     (narrow_i),
    .pc_q       (pc_o),
    .fetch_addr (fetch_addr)
  );

  fp_fill_track u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (do_step),
    .load      (do_flush),
    .narrow    (narrow_i),
    .raw       (mem_rdata_i),
    .pend      (fill_pend),
    .fill_word (fill_word)
  );

  fp_slot_chain u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (do_step),
    .load      (do_flush),
    .pend      (fill_pend),
    .fill_word (fill_word),
    .new_addr  (fetch_addr),
    .slots     (slots)
  );

  assign mem_req_o  = do_step;
  assign mem_addr_o = fetch_addr;
  assign mem_half_o = narrow_i;

  assign fet_vld_o  = slots[S_FET].vld;
  assign fet_addr_o = slots[S_FET].addr;
  assign fet_insn_o = slots[S_FET].insn;
  assign dec_vld_o  = slots[S_DEC].vld;
  assign dec_addr_o = slots[S_DEC].addr;
  assign dec_insn_o = slots[S_DEC].insn;
  assign exe_vld_o  = slots[S_EXE].vld;
  assign exe_addr_o = slots[S_EXE].addr;
  assign exe_insn_o = slots[S_EXE].insn;
endmodule

// File: rtl/fetch_pipe_chk.sv
module fetch_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step_i,
  input logic        narrow_i,
  input logic        redir_i,
  input logic [31:0] redir_pc_i,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_half_o,
  input logic [31:0] pc_o,
  input logic        fet_vld_o,
  input logic [31:0] fet_addr_o,
  input logic        dec_vld_o,
  input logic [31:0] dec_addr_o,
  input logic [31:0] dec_insn_o,
  input logic        exe_vld_o,
  input logic [31:0] exe_addr_o,
  input logic [31:0] exe_insn_o,
  input logic        do_step,
  input logic        do_flush
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> dec_vld_o == $past(fet_vld_o) && dec_addr_o == $past(fet_addr_o) &&
                exe_vld_o == $past(dec_vld_o) && exe_addr_o == $past(dec_addr_o) &&
                exe_insn_o == $past(dec_insn_o));

  p_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !narrow_i |-> mem_addr_o[1:0] == 2'b00 && !mem_half_o);

  p_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && narrow_i |-> !mem_addr_o[0] && mem_half_o);

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> fet_vld_o &&
                (pc_o - $past(pc_o)) == ($past(narrow_i) ? 32'd2 : 32'd4) &&
                fet_addr_o == ($past(narrow_i) ? {pc_o[31:1], 1'b0} : {pc_o[31:2], 2'b00}));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush |=> !fet_vld_o && !dec_vld_o && !exe_vld_o && pc_o == $past(redir_pc_i));

  p_flush_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_i |-> !mem_req_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !redir_i |=> $stable(pc_o) && $stable(dec_vld_o) && $stable(dec_addr_o) &&
                            $stable(dec_insn_o) && $stable(exe_vld_o) && $stable(exe_insn_o));
endmodule

bind fetch_pipe fetch_pipe_chk u_chk (.*);

// File: tb/fetch_pipe_tb.sv
module fetch_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic        narrow_i = 1'b0;
  logic        redir_i = 1'b0;
  logic [31:0] redir_pc_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_half_o;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] pc_o;
  logic        fet_vld_o, dec_vld_o, exe_vld_o;
  logic [31:0] fet_addr_o, dec_addr_o, exe_addr_o;
  logic [31:0] fet_insn_o, dec_insn_o, exe_insn_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fetch_pipe u_dut (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // Synchronous instruction memory: data one clock after the request.
  always @(posedge clk) if (mem_req_o) mem_rdata_i <= mem_word(mem_addr_o);

  // Behavioural reference: a queue of slot records, index 0 = fetch.
  typedef struct {
    bit          vld;
    logic [31:0] addr;
    logic [31:0] insn;
    bit          half;
  } ent_t;
  ent_t        q[$];
  logic [31:0] m_pc;
  bit          m_pend;
  bit          m_half;
  string       last_act = "R1";

  function automatic logic [31:0] expect_word(input logic [31:0] raw, input bit half);
    return half ? (raw & 32'h0000_FFFF) : raw;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 3; i++) q.push_back('{vld: 0, addr: 0, insn: 0, half: 0});
      m_pc   = 0;
      m_pend = 0;
      m_half = 0;
    end else if (redir_i) begin
      m_pc = redir_pc_i;
      foreach (q[i]) q[i].vld = 0;
      m_pend = 0;
    end else if (step_i) begin
      int unsigned stride;
      ent_t e;
      stride = narrow_i ? 2 : 4;
      if (m_pend) q[0].insn = expect_word(mem_rdata_i, m_half);
      m_pc   = m_pc + stride;
      e.vld  = 1;
      e.addr = narrow_i ? (m_pc & ~32'd1) : (m_pc & ~32'd3);
      e.insn = 0;
      e.half = narrow_i;
      q.push_front(e);
      void'(q.pop_back());
      m_pend = 1;
      m_half = narrow_i;
    end else if (m_pend) begin
      q[0].insn = expect_word(mem_rdata_i, m_half);
      m_pend = 0;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_state();
    string ptag, stag;
    ptag = last_act;
    stag = (last_act == "R3" || last_act == "R4") ? "R2" : last_act;
    chk(ptag, "pc", pc_o, m_pc);
    chk(last_act == "R8" ? "R8" : "R5", "fetch valid", 32'(fet_vld_o), 32'(q[0].vld));
    chk(stag, "decode valid", 32'(dec_vld_o), 32'(q[1].vld));
    chk(stag, "execute valid", 32'(exe_vld_o), 32'(q[2].vld));
    if (q[0].vld) begin
      chk("R5", "fetch addr", fet_addr_o, q[0].addr);
      chk("R6", "fetch insn", fet_insn_o, q[0].insn);
      if (q[0].half) chk("R7", "fetch insn upper", {16'h0, fet_insn_o[31:16]}, 32'h0);
    end
    if (q[1].vld) begin
      chk(stag, "decode addr", dec_addr_o, q[1].addr);
      chk("R6", "decode insn", dec_insn_o, q[1].insn);
      if (q[1].half) chk("R7", "decode insn upper", {16'h0, dec_insn_o[31:16]}, 32'h0);
    end
    if (q[2].vld) begin
      chk(stag, "execute addr", exe_addr_o, q[2].addr);
      chk("R2", "execute insn", exe_insn_o, q[2].insn);
    end
  endtask

  task automatic compare_req();
    string mtag;
    logic [31:0] np;
    mtag = narrow_i ? "R4" : "R3";
    np   = m_pc + (narrow_i ? 32'd2 : 32'd4);
    chk(redir_i ? "R8" : mtag, "request", 32'(mem_req_o), 32'(step_i && !redir_i));
    if (step_i && !redir_i) begin
      chk(mtag, "request addr", mem_addr_o, narrow_i ? (np & ~32'd1) : (np & ~32'd3));
      chk(mtag, "request size", 32'(mem_half_o), 32'(narrow_i));
    end
  endtask

  task automatic cyc(input bit st, input bit nar, input bit rd, input logic [31:0] rpc);
    @(negedge clk);
    compare_state();
    step_i     = st;
    narrow_i   = nar;
    redir_i    = rd;
    redir_pc_i = rpc;
    #1;
    compare_req();
    last_act = rd ? "R8" : (st ? (nar ? "R4" : "R3") : "R9");
  endtask

  initial begin
    fork
      begin
        logic [15:0] lfsr;
        bit nar;
        repeat (3) @(negedge clk);
        // R1: state held in reset, then just after release
        chk("R1", "pc in reset", pc_o, 32'h0);
        chk("R1", "valids in reset", {29'h0, fet_vld_o, dec_vld_o, exe_vld_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pc after reset", pc_o, 32'h0);
        chk("R1", "valids after reset", {29'h0, fet_vld_o, dec_vld_o, exe_vld_o}, 32'h0);
        chk("R1", "no request", 32'(mem_req_o), 32'h0);
        // R3: back-to-back word fetches
        repeat (6) cyc(1, 0, 0, 0);
        // R9: idle gaps between steps
        repeat (3) cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); cyc(1, 0, 0, 0);
        // R4, R7: halfword fetches, with and without gaps
        repeat (5) cyc(1, 1, 0, 0);
        cyc(0, 1, 0, 0); cyc(1, 1, 0, 0); cyc(0, 1, 0, 0);
        // R8: redirect to an unaligned target, together with a step
        cyc(1, 1, 1, 32'h0000_1003);
        repeat (4) cyc(1, 1, 0, 0);
        repeat (4) cyc(1, 0, 0, 0);
        // R8: redirect while a read is outstanding discards it
        cyc(1, 0, 0, 0);
        cyc(0, 0, 1, 32'h0000_2001);
        cyc(0, 0, 0, 0);
        repeat (3) cyc(1, 0, 0, 0);
        // Mixed pattern
        lfsr = 16'hACE1;
        nar  = 0;
        for (int i = 0; i < 400; i++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          if (lfsr[3:0] == 4'h5) nar = ~nar;
          cyc(lfsr[7:5] != 3'b000, nar, lfsr[11:7] == 5'h1F,
              {lfsr, lfsr[7:0], lfsr[15:8]});
        end
        cyc(0, 0, 0, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule